// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block is an 8-bit status register that sits on a peripheral bus. It collects interrupt flags from three timer events and turns them into interrupt requests. The three events are a timer 0 overflow, a timer 1 compare-match on channel B, and a timer 1 input capture. A one-cycle strobe from the timer logic raises the matching flag.

A flag is lowered in one of two ways. Software can write a one to the flag's bit. The interrupt controller can also pulse an acknowledge line when it takes that flag's vector. Each flag is combined with its own enable bit and with a global interrupt enable to form a request line.

Every flag is held by a small two-state machine. The states are FLAG_IDLE and FLAG_PEND. The transitions are:

- IDLE to PEND on a set strobe.
- PEND to IDLE on a clear, but only when no set arrives in the same cycle.
- Every other combination holds the state.

A bus read returns a registered copy of the register one cycle after the address is presented.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset all flags are zero, `bus_rdata` is zero and every request output is low.
- R2: A pulse on `ev_ovf0` sets the timer 0 overflow flag, which reads at bit 1 from the next cycle on.
- R3: A pulse on `ev_cmpb1` sets the timer 1 compare-B flag, which reads at bit 5 from the next cycle on.
- R4: A pulse on `ev_cap1` sets the timer 1 capture flag, which reads at bit 3 from the next cycle on.
- R5: A bus write to the register address clears every flag whose bit position in `bus_wdata` is one.
- R6: Writing zero to a flag's bit position leaves that flag unchanged.
- R7: A pulse on an acknowledge input (`ack_ovf0`, `ack_cmpb1` or `ack_cap1`) clears the matching flag in the next cycle.
- R8: When a set strobe and a clear (a write of one or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: Bits 7, 6, 4, 2 and 0 are reserved and always read as zero, even after a write of ones to them.
- R10: Each request output is high exactly when `glob_ie`, that flag's enable input and the flag itself are all high.
- R11: A read with `bus_sel` high, `bus_we` low and `bus_addr` equal to `REG_ADDR` returns the flag values in `bus_rdata` on the next cycle. A read of any other address returns zero, and a write to any other address changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ovf0 | input | 1 | Timer 0 overflow strobe |
| ev_cmpb1 | input | 1 | Timer 1 compare-B strobe |
| ev_cap1 | input | 1 | Timer 1 input capture strobe |
| ack_ovf0 | input | 1 | Vector taken for the overflow flag |
| ack_cmpb1 | input | 1 | Vector taken for the compare-B flag |
| ack_cap1 | input | 1 | Vector taken for the capture flag |
| glob_ie | input | 1 | Global interrupt enable |
| en_ovf0 | input | 1 | Overflow request enable |
| en_cmpb1 | input | 1 | Compare-B request enable |
| en_cap1 | input | 1 | Capture request enable |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data; a one in a flag position clears that flag |
| bus_rdata | output | 8 | Registered read data |
| irq_ovf0 | output | 1 | Overflow interrupt request |
| irq_cmpb1 | output | 1 | Compare-B interrupt request |
| irq_cap1 | output | 1 | Capture interrupt request |

## Verification
A flag changes one clock edge after its strobe, write or acknowledge. The request outputs follow that flag within the same cycle, because they are gated combinationally. Read data is due on the first clock edge after the address cycle and reflects the flags as they stood in that address cycle.

The bench applies stimulus at the falling edge. It checks the request outputs at the next falling edge. The scoreboard monitor records each read at the rising edge that captures it, then compares `bus_rdata` 5 ns after that edge against the value the driver queued.

// File: rtl/tif_pkg.sv
package tif_pkg;

    // Number of timer flags held in the register.
    localparam int unsigned NUM_FLAGS = 3;
    localparam int unsigned DATA_W    = 8;

    // Internal flag index to register bit position.
    // Index 0: timer 0 overflow, 1: timer 1 compare-B, 2: timer 1 capture.
    localparam int unsigned FLAG_BIT [NUM_FLAGS] = '{1, 5, 3};

    // Bits that read as zero.
    localparam logic [DATA_W-1:0] RSV_MASK = 8'b1101_0101;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_st_e;

endpackage

// File: rtl/tif_flag_fsm.sv
module tif_flag_fsm
    import tif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_st_e st_q;
    flag_st_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: a set strobe always wins over a clear
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: begin
                if (set_i) st_d = FLAG_PEND;
            end
            FLAG_PEND: begin
                if (clr_i && !set_i) st_d = FLAG_IDLE;
            end
            default: st_d = FLAG_IDLE;
        endcase
    end

    // Output
    always_comb begin
        unique case (st_q)
            FLAG_PEND: flag_o = 1'b1;
            default:   flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tif_bus_port.sv
module tif_bus_port
    import tif_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h38
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_FLAGS-1:0] flag_i,
    output logic [NUM_FLAGS-1:0] wclr_o,
    output logic [DATA_W-1:0]    rdata_o
);

    logic              hit;
    logic [DATA_W-1:0] view;

    assign hit = bus_sel && (bus_addr == REG_ADDR);

    // Write-one-to-clear decode, one strobe per flag
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_wclr
        assign wclr_o[g] = hit && bus_we && bus_wdata[FLAG_BIT[g]];
    end

    // Register view: reserved positions stay zero
    always_comb begin
        view = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            view[FLAG_BIT[i]] = flag_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (hit && !bus_we) begin
            rdata_o <= view;
        end else begin
            rdata_o <= '0;
        end
    end

endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate
    import tif_pkg::*;
(
    input  logic                 glob_ie,
    input  logic [NUM_FLAGS-1:0] en_i,
    input  logic [NUM_FLAGS-1:0] flag_i,
    output logic [NUM_FLAGS-1:0] irq_o
);

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_req
        assign irq_o[g] = glob_ie & en_i[g] & flag_i[g];
    end

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tif_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ovf0,
    input  logic              ev_cmpb1,
    input  logic              ev_cap1,
    input  logic              ack_ovf0,
    input  logic              ack_cmpb1,
    input  logic              ack_cap1,
    input  logic              glob_ie,
    input  logic              en_ovf0,
    input  logic              en_cmpb1,
    input  logic              en_cap1,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_ovf0,
    output logic              irq_cmpb1,
    output logic              irq_cap1
);

    logic [NUM_FLAGS-1:0] ev_v;
    logic [NUM_FLAGS-1:0] ack_v;
    logic [NUM_FLAGS-1:0] en_v;
    logic [NUM_FLAGS-1:0] wclr_v;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] irq_v;

    assign ev_v  = {ev_cap1,  ev_cmpb1,  ev_ovf0};
    assign ack_v = {ack_cap1, ack_cmpb1, ack_ovf0};
    assign en_v  = {en_cap1,  en_cmpb1,  en_ovf0};

    tif_bus_port #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag_i    (flag_q),
        .wclr_o    (wclr_v),
        .rdata_o   (bus_rdata)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        tif_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ev_v[g]),
            .clr_i  (wclr_v[g] | ack_v[g]),
            .flag_o (flag_q[g])
        );
    end

    tif_irq_gate u_gate (
        .glob_ie (glob_ie),
        .en_i    (en_v),
        .flag_i  (flag_q),
        .irq_o   (irq_v)
    );

    assign irq_ovf0  = irq_v[0];
    assign irq_cmpb1 = irq_v[1];
    assign irq_cap1  = irq_v[2];

endmodule

// File: rtl/tif_checks.sv
module tif_checks
    import tif_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] ev,
    input logic [NUM_FLAGS-1:0] ack,
    input logic [NUM_FLAGS-1:0] en,
    input logic                 gie,
    input logic                 bus_we,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] irqs,
    input logic [DATA_W-1:0]    rdata
);

    p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> flags[0]);

    p_cmpb_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev[1] |=> flags[1]);

    p_cap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev[2] |=> flags[2]);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !ack[0] && !bus_we) |=> flags[0]);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[2] && !ev[2]) |=> !flags[2]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[0] && ack[0]) |=> flags[0]);

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & RSV_MASK) == '0);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irqs[1] |-> (gie && en[1] && flags[1]));

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irqs == '0));

endmodule

bind tmr_irq_flags tif_checks u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev_v),
    .ack    (ack_v),
    .en     (en_v),
    .gie    (glob_ie),
    .bus_we (bus_we),
    .flags  (flag_q),
    .irqs   (irq_v),
    .rdata  (bus_rdata)
);

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;

    localparam int unsigned AW  = 6;
    localparam logic [AW-1:0] RA = 6'h38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_ovf0 = 0, ev_cmpb1 = 0, ev_cap1 = 0;
    logic ack_ovf0 = 0, ack_cmpb1 = 0, ack_cap1 = 0;
    logic glob_ie = 0, en_ovf0 = 0, en_cmpb1 = 0, en_cap1 = 0;
    logic bus_sel = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq_ovf0, irq_cmpb1, irq_cap1;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] mdl = '0;      // expected register contents
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 0;

    always #10 clk = ~clk;     // 50 MHz

    tmr_irq_flags #(.ADDR_W(AW), .REG_ADDR(RA)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_ovf0(ev_ovf0), .ev_cmpb1(ev_cmpb1), .ev_cap1(ev_cap1),
        .ack_ovf0(ack_ovf0), .ack_cmpb1(ack_cmpb1), .ack_cap1(ack_cap1),
        .glob_ie(glob_ie), .en_ovf0(en_ovf0), .en_cmpb1(en_cmpb1), .en_cap1(en_cap1),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ovf0(irq_ovf0), .irq_cmpb1(irq_cmpb1), .irq_cap1(irq_cap1)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: a read captured at a rising edge is compared 5 ns later
    always begin
        logic took;
        @(posedge clk);
        took = bus_sel && !bus_we && rst_n;
        #5;
        if (took && exp_q.size() > 0) begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Driver: one bus/event cycle; model updated with set-wins rule
    task automatic cyc(input logic sel, input logic we, input logic [AW-1:0] a,
                       input logic [7:0] wd, input logic [2:0] ev,
                       input logic [2:0] ack, input string tag);
        logic [7:0] setm, clrm;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
        {ev_cap1, ev_cmpb1, ev_ovf0} = ev;
        {ack_cap1, ack_cmpb1, ack_ovf0} = ack;
        if (sel && !we) begin
            exp_q.push_back((a == RA) ? mdl : 8'h00);
            tag_q.push_back(tag);
        end
        setm = {2'b00, ev[1], 1'b0, ev[2], 1'b0, ev[0], 1'b0};
        clrm = {2'b00, ack[1], 1'b0, ack[2], 1'b0, ack[0], 1'b0};
        if (sel && we && a == RA) clrm |= wd & 8'h2A;
        mdl = (mdl & ~clrm) | setm;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
        {ev_cap1, ev_cmpb1, ev_ovf0} = '0;
        {ack_cap1, ack_cmpb1, ack_ovf0} = '0;
    endtask

    task automatic rd(input string tag);
        cyc(1, 0, RA, 8'h00, 3'b000, 3'b000, tag);
    endtask

    initial begin
        #2000000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({5'b0, irq_cap1, irq_cmpb1, irq_ovf0}, 8'h00, "R1 irq after reset");
        check(bus_rdata, 8'h00, "R1 rdata after reset");
        rst_n = 1;
        rd("R1 flags after reset");

        glob_ie = 1; en_ovf0 = 1; en_cmpb1 = 1; en_cap1 = 1;
        cyc(0, 0, RA, 0, 3'b001, 3'b000, "R2");
        check({7'b0, irq_ovf0}, 8'h01, "R10 overflow request");
        rd("R2 overflow flag at bit 1");
        glob_ie = 0;
        @(negedge clk);
        check({5'b0, irq_cap1, irq_cmpb1, irq_ovf0}, 8'h00, "R10 global enable off");
        glob_ie = 1; en_ovf0 = 0;
        @(negedge clk);
        check({7'b0, irq_ovf0}, 8'h00, "R10 own enable off");

        cyc(0, 0, RA, 0, 3'b010, 3'b000, "R3");
        rd("R3 compare-B flag at bit 5");
        check({7'b0, irq_cmpb1}, 8'h01, "R10 compare-B request");
        cyc(0, 0, RA, 0, 3'b100, 3'b000, "R4");
        rd("R4 capture flag at bit 3");
        check({7'b0, irq_cap1}, 8'h01, "R10 capture request");

        cyc(1, 1, RA, 8'h00, 3'b000, 3'b000, "R6");
        rd("R6 write zero keeps flags");
        cyc(1, 1, RA, 8'hD5, 3'b000, 3'b000, "R9");
        rd("R9 reserved write ignored");

        cyc(1, 1, RA, 8'h02, 3'b000, 3'b000, "R5");
        rd("R5 write one clears overflow");

        cyc(0, 0, RA, 0, 3'b000, 3'b100, "R7");
        rd("R7 acknowledge clears capture");
        check({7'b0, irq_cap1}, 8'h00, "R7 capture request dropped");

        cyc(1, 1, RA, 8'h20, 3'b010, 3'b000, "R8");
        rd("R8 set wins over write clear");
        cyc(0, 0, RA, 0, 3'b001, 3'b001, "R8");
        rd("R8 set wins over acknowledge");

        cyc(1, 1, RA ^ 6'h01, 8'hFF, 3'b000, 3'b000, "R11");
        rd("R11 foreign write ignored");
        cyc(1, 0, RA ^ 6'h04, 8'h00, 3'b000, 3'b000, "R11 foreign read zero");

        cyc(1, 1, RA, 8'hFF, 3'b000, 3'b000, "R5");
        rd("R5 all flags cleared");

        repeat (2) @(negedge clk);
        check(8'(exp_q.size()), 8'h00, "R11 all reads returned");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule